// File: doc/BRIEF.md
# Piecewise Linear Sigmoid Approximator

This block turns a signed fixed-point activation into a sigmoid-like output by evaluating a piecewise linear curve of a parameterised number of segments. It is meant for a neuron datapath, for example inside a Hopfield network, where it stands in for a lookup table. A simple write port loads each segment's right-hand breakpoint, each segment's slope and one fallback value. A start pulse then makes the block derive every segment's starting intercept by itself, one segment per clock, while `busy` is high. Since each intercept is built from the previous segment's end point, the curve has no jumps.

Each sample is taken relative to its own segment's left breakpoint. The block scales that offset by the segment slope, rounds, adds the segment's starting intercept and saturates the result. Negative inputs are mirrored around the midpoint of the output range. Samples enter and leave on valid/ready streams. A sample is taken only in a cycle where `in_valid` and `in_ready` are both high. A result is offered until the cycle in which `out_ready` is high. While the output is stalled, the whole three-stage pipeline holds its contents and `in_ready` is low, so no sample is lost or duplicated.

Top module: `pwl_sigmoid`

## Requirements
- R1: After reset, `out_valid` is 0, `busy` is 0 and `in_ready` is 1 while `start` is low.
- R2: Segment j (0-based) covers magnitudes x with lo(j) <= x < bp(j), where lo(0) = 0 and lo(j) = bp(j-1). The lowest covering segment is chosen.
- R3: For a selected segment the result is y = ((m(j) * (x - lo(j)) + 2048) >> 12) + n(j). Here x is unsigned Q4.12 in `in_data[15:0]`, the slope m is unsigned Q1.15, and y is unsigned Q1.15.
- R4: The starting intercepts obey n(0) = 0 and n(j+1) = min(32768, ((m(j) * d + 2048) >> 12) + n(j)). Here d = bp(j) - lo(j), or 0 if that is negative.
- R5: A magnitude that no segment covers yields the programmed fallback value in place of y.
- R6: y is clamped to 32768 (1.0), so `out_data` never exceeds 32768.
- R7: When `in_data[16]` (the sign) is 1, `out_data` = 32768 - y(|x|).
- R8: A sample accepted in cycle c, with no stall, appears on `out_valid`/`out_data` in cycle c+3. Results leave in acceptance order.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold and `in_ready` is 0.
- R10: A `start` is honoured when `busy` is 0 and no sample sits in the first stage. `busy` is then 1 for exactly NSEG-1 cycles from the next cycle. `in_ready` is 0 while `busy` is 1 and in any cycle in which `start` is 1. `start` and configuration writes are ignored while `busy` is 1.
- R11: On a configuration write, `cfg_kind` selects the target: 0 is a breakpoint, 1 is a slope and 2 is the fallback. `cfg_idx` is the 0-based segment number, and `cfg_data` is the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with in_valid |
| in_data | input | 17 | Bit 16 is the sign; bits 15:0 are the Q4.12 magnitude |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 16 | Q1.15 result, 0 to 32768 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 breakpoint, 1 slope, 2 fallback |
| cfg_idx | input | 3 | Segment number of the write |
| cfg_data | input | 16 | Value written |
| start | input | 1 | Begin intercept derivation |
| busy | output | 1 | Intercepts are being derived |

## Verification
The bench holds a behavioural reference that computes each result from the formulas when the sample is accepted. It carries that result through three model stages, which advance only when the output is free or taken. So a sample accepted in cycle c is expected on the output in cycle c+3, or later by exactly the number of stalled cycles. Every cycle, half a clock after the inputs change and just before the next rising edge, the bench compares `out_valid`, `out_data`, `busy` and `in_ready` with the model. The model raises `busy` in the cycle after an honoured start and lowers it NSEG-1 cycles later. It recomputes `in_ready` from its own busy state, the current `start` and `out_ready`, and the state of its own last stage.

// File: rtl/pwl_pkg.sv
`timescale 1ns/1ps
package pwl_pkg;
  localparam int IN_W     = 16;
  localparam int IN_FRAC  = 12;
  localparam int M_W      = 16;
  localparam int M_FRAC   = 15;
  localparam int OUT_W    = 16;
  localparam int OUT_FRAC = 15;
  localparam int CFG_W    = 16;
  localparam int SHIFT    = IN_FRAC + M_FRAC - OUT_FRAC;
  localparam int PROD_W   = IN_W + M_W;
  localparam int RND_W    = PROD_W - SHIFT + 1;
  localparam logic [OUT_W-1:0] ONE = OUT_W'(1) << OUT_FRAC;

  typedef enum logic [1:0] {
    CFG_BP       = 2'd0,
    CFG_SLOPE    = 2'd1,
    CFG_FALLBACK = 2'd2
  } cfg_kind_e;

  function automatic logic [OUT_W-1:0] sat_add(input logic [RND_W-1:0] r,
                                               input logic [OUT_W-1:0] n);
    logic [RND_W:0] s;
    s = {1'b0, r} + {{(RND_W+1-OUT_W){1'b0}}, n};
    if (s > {{(RND_W+1-OUT_W){1'b0}}, ONE}) return ONE;
    return s[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/pwl_mulrnd.sv
`timescale 1ns/1ps
module pwl_mulrnd
  import pwl_pkg::*;
(
  input  logic [M_W-1:0]   mul_a,
  input  logic [IN_W-1:0]  mul_b,
  output logic [RND_W-1:0] rnd
);
  localparam logic [PROD_W:0] HALF = (PROD_W+1)'(1) << (SHIFT-1);
  logic [PROD_W-1:0] prod;
  logic [PROD_W:0]   biased;

  always_comb begin
    prod   = PROD_W'(mul_a) * PROD_W'(mul_b);
    biased = {1'b0, prod} + HALF;
    rnd    = biased[PROD_W:SHIFT];
  end
endmodule

// File: rtl/pwl_cfg_regs.sv
`timescale 1ns/1ps
module pwl_cfg_regs
  import pwl_pkg::*;
#(
  parameter int NSEG  = 8,
  parameter int IDX_W = $clog2(NSEG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [1:0]                  kind,
  input  logic [IDX_W-1:0]            idx,
  input  logic [CFG_W-1:0]            data,
  input  logic                        lock,
  output logic [NSEG-1:0][IN_W-1:0]   bp,
  output logic [NSEG-1:0][M_W-1:0]    slope,
  output logic [OUT_W-1:0]            fallback
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp       <= '0;
      slope    <= '0;
      fallback <= '0;
    end else if (we && !lock) begin
      unique case (kind)
        CFG_BP: begin
          for (int i = 0; i < NSEG; i++)
            if (int'(idx) == i) bp[i] <= data[IN_W-1:0];
        end
        CFG_SLOPE: begin
          for (int i = 0; i < NSEG; i++)
            if (int'(idx) == i) slope[i] <= data[M_W-1:0];
        end
        CFG_FALLBACK: fallback <= data[OUT_W-1:0];
        default: ;
      endcase
    end
  end

  // R10
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(bp) && $stable(slope) && $stable(fallback)));
endmodule

// File: rtl/pwl_icept_seq.sv
`timescale 1ns/1ps
module pwl_icept_seq
  import pwl_pkg::*;
#(
  parameter int NSEG   = 8,
  parameter int STEP_W = $clog2(NSEG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go,
  input  logic [NSEG-1:0][IN_W-1:0]  bp,
  input  logic [NSEG-1:0][M_W-1:0]   slope,
  input  logic [RND_W-1:0]           rnd,
  output logic                       busy,
  output logic [M_W-1:0]             mul_a,
  output logic [IN_W-1:0]            mul_b,
  output logic [NSEG-1:0][OUT_W-1:0] icpt
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NSEG - 2);
  logic [STEP_W-1:0] step;
  logic [IN_W-1:0]   lo, hi;

  always_comb begin
    hi    = bp[step];
    lo    = (step == '0) ? '0 : bp[step - 1'b1];
    mul_a = slope[step];
    mul_b = (hi >= lo) ? (hi - lo) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      icpt <= '0;
    end else if (busy) begin
      icpt[step + 1'b1] <= sat_add(rnd, icpt[step]);
      if (step == LAST) busy <= 1'b0;
      else              step <= step + 1'b1;
    end else if (go) begin
      busy <= 1'b1;
      step <= '0;
    end
  end

  // R10
  seq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == LAST) |=> !busy);
  // R4
  seq_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (step == '0 && icpt[0] == '0));
endmodule

// File: rtl/pwl_segsel.sv
`timescale 1ns/1ps
module pwl_segsel
  import pwl_pkg::*;
#(
  parameter int NSEG = 8
) (
  input  logic [IN_W-1:0]            x,
  input  logic [NSEG-1:0][IN_W-1:0]  bp,
  input  logic [NSEG-1:0][M_W-1:0]   slope,
  input  logic [NSEG-1:0][OUT_W-1:0] icpt,
  input  logic [OUT_W-1:0]           fallback,
  output logic [M_W-1:0]             m,
  output logic [IN_W-1:0]            dv,
  output logic [OUT_W-1:0]           n
);
  logic [NSEG-1:0]            inrange;
  logic [NSEG-1:0]            sel_oh;
  logic [NSEG-1:0][IN_W-1:0]  lo;
  logic                       taken;

  for (genvar i = 0; i < NSEG; i++) begin : g_cmp
    if (i == 0) begin : g_first
      assign lo[i] = '0;
    end else begin : g_rest
      assign lo[i] = bp[i-1];
    end
    assign inrange[i] = (x >= lo[i]) && (x < bp[i]);
  end

  always_comb begin
    sel_oh = '0;
    taken  = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      if (inrange[i] && !taken) begin
        sel_oh[i] = 1'b1;
        taken     = 1'b1;
      end
    end
    m  = '0;
    dv = '0;
    n  = taken ? '0 : fallback;
    for (int i = 0; i < NSEG; i++) begin
      if (sel_oh[i]) begin
        m  = m  | slope[i];
        dv = dv | (x - lo[i]);
        n  = n  | icpt[i];
      end
    end
  end

  // R2
  always_comb begin
    if (!$isunknown(inrange))
      segsel_onehot_chk: assert ($onehot0(sel_oh) && ((|sel_oh) == (|inrange)));
  end
endmodule

// File: rtl/pwl_sigmoid.sv
`timescale 1ns/1ps
module pwl_sigmoid
  import pwl_pkg::*;
#(
  parameter int NSEG  = 8,
  parameter int IDX_W = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              start,
  output logic              busy
);
  logic [NSEG-1:0][IN_W-1:0]  bp;
  logic [NSEG-1:0][M_W-1:0]   slope;
  logic [NSEG-1:0][OUT_W-1:0] icpt;
  logic [OUT_W-1:0]           fallback;

  logic [M_W-1:0]   sel_m, seq_a, mul_a;
  logic [IN_W-1:0]  sel_dv, seq_b, mul_b;
  logic [OUT_W-1:0] sel_n;
  logic [RND_W-1:0] rnd;

  logic             advance, accept, go;
  logic             s1_v, s1_sign, s2_v, s2_sign;
  logic [M_W-1:0]   s1_m;
  logic [IN_W-1:0]  s1_dv;
  logic [OUT_W-1:0] s1_n, s2_n, y;
  logic [RND_W-1:0] s2_r;

  assign advance  = !out_valid || out_ready;
  assign in_ready = !busy && !start && advance;
  assign accept   = in_valid && in_ready;
  assign go       = start && !busy && !s1_v;

  pwl_cfg_regs #(.NSEG(NSEG), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .kind(cfg_kind), .idx(cfg_idx),
    .data(cfg_data), .lock(busy), .bp(bp), .slope(slope), .fallback(fallback)
  );

  pwl_icept_seq #(.NSEG(NSEG)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .bp(bp), .slope(slope), .rnd(rnd),
    .busy(busy), .mul_a(seq_a), .mul_b(seq_b), .icpt(icpt)
  );

  pwl_segsel #(.NSEG(NSEG)) u_sel (
    .x(in_data[IN_W-1:0]), .bp(bp), .slope(slope), .icpt(icpt),
    .fallback(fallback), .m(sel_m), .dv(sel_dv), .n(sel_n)
  );

  assign mul_a = busy ? seq_a : s1_m;
  assign mul_b = busy ? seq_b : s1_dv;

  pwl_mulrnd u_mul (.mul_a(mul_a), .mul_b(mul_b), .rnd(rnd));

  assign y = sat_add(s2_r, s2_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_sign <= 1'b0; s1_m <= '0; s1_dv <= '0; s1_n <= '0;
      s2_v <= 1'b0; s2_sign <= 1'b0; s2_r <= '0; s2_n <= '0;
      out_valid <= 1'b0; out_data <= '0;
    end else if (advance) begin
      s1_v <= accept;
      if (accept) begin
        s1_sign <= in_data[IN_W];
        s1_m    <= sel_m;
        s1_dv   <= sel_dv;
        s1_n    <= sel_n;
      end
      s2_v <= s1_v;
      if (s1_v) begin
        s2_sign <= s1_sign;
        s2_r    <= rnd;
        s2_n    <= s1_n;
      end
      out_valid <= s2_v;
      if (s2_v) out_data <= s2_sign ? (ONE - y) : y;
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R6
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data <= ONE));
  // R10
  busy_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!s1_v && !in_ready));
  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept, 3) && $past(advance, 2) && $past(advance, 1)) |-> out_valid);
endmodule

// File: tb/tb_pwl_sigmoid.sv
`timescale 1ns/1ps
module tb_pwl_sigmoid;
  localparam int N   = 8;
  localparam int ONE = 32768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [16:0] in_data = '0;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_data;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [2:0]  cfg_idx = '0;
  logic [15:0] cfg_data = '0;
  logic        start = 1'b0;
  logic        busy;

  always #2.5 clk = ~clk;

  pwl_sigmoid #(.NSEG(N)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .start(start), .busy(busy)
  );

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit    bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int mbp[N], msl[N], mic[N], mfb;
  bit mbusy; int mcnt;
  bit pv[3]; int pd[3];
  bit m_acc;

  function automatic int rnd12(longint p);
    return int'((p + 2048) >>> 12);
  endfunction

  function automatic int f_eval(bit s, int x);
    int y, lo; bit found;
    found = 0; y = 0;
    for (int j = 0; j < N; j++) begin
      lo = (j == 0) ? 0 : mbp[j-1];
      if (!found && x >= lo && x < mbp[j]) begin
        found = 1;
        y = rnd12(longint'(msl[j]) * longint'(x - lo)) + mic[j];
      end
    end
    if (!found) y = mfb;
    if (y > ONE) y = ONE;
    return s ? ONE - y : y;
  endfunction

  task automatic calc_icpt();
    int lo, d, v;
    mic[0] = 0;
    for (int j = 0; j < N-1; j++) begin
      lo = (j == 0) ? 0 : mbp[j-1];
      d = mbp[j] - lo;
      if (d < 0) d = 0;
      v = rnd12(longint'(msl[j]) * longint'(d)) + mic[j];
      mic[j+1] = (v > ONE) ? ONE : v;
    end
  endtask

  always @(negedge clk) begin
    if (bp_mode) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= lfsr[0] | lfsr[3];
    end else out_ready <= 1'b1;
  end

  always @(posedge clk) begin
    bit adv, rdy, go;
    if (!rst_n) begin
      for (int j = 0; j < N; j++) begin mbp[j] = 0; msl[j] = 0; mic[j] = 0; end
      mfb = 0; mbusy = 0; mcnt = 0; m_acc = 0;
      for (int k = 0; k < 3; k++) begin pv[k] = 0; pd[k] = 0; end
    end else begin
      adv = !pv[2] || out_ready;
      rdy = !mbusy && !start && adv;
      m_acc = in_valid && rdy;
      go = start && !mbusy && !pv[0];
      if (adv) begin
        pv[2] = pv[1]; pd[2] = pd[1];
        pv[1] = pv[0]; pd[1] = pd[0];
        pv[0] = m_acc;
        if (m_acc) pd[0] = f_eval(in_data[16], int'(in_data[15:0]));
      end
      if (cfg_we && !mbusy) begin
        case (cfg_kind)
          2'd0: mbp[cfg_idx] = int'(cfg_data);
          2'd1: msl[cfg_idx] = int'(cfg_data);
          2'd2: mfb = int'(cfg_data);
          default: ;
        endcase
      end
      if (mbusy) begin
        if (mcnt == 1) mbusy = 0;
        mcnt = mcnt - 1;
      end else if (go) begin
        mbusy = 1; mcnt = N - 1;
        calc_icpt();
      end
    end
  end

  task automatic chk(bit ok, string what, int got, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got %0d expected %0d at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(out_valid == pv[2], "out_valid", int'(out_valid), int'(pv[2]));
      if (pv[2] && out_valid) chk(int'(out_data) == pd[2], "out_data", int'(out_data), pd[2]);
      chk(busy == mbusy, "busy", int'(busy), int'(mbusy));
      chk(in_ready == (!mbusy && !start && (!pv[2] || out_ready)), "in_ready",
          int'(in_ready), int'(!mbusy && !start && (!pv[2] || out_ready)));
    end
  end

  task automatic wr(int kind, int idx, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_idx = 3'(idx); cfg_data = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(bit s, int mag);
    @(negedge clk);
    in_valid = 1'b1; in_data = {s, 16'(mag)};
    do begin @(posedge clk); #0.1; end while (!m_acc);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic stream(bit s, int base, int stepv, int cnt);
    @(negedge clk);
    for (int k = 0; k < cnt; k++) begin
      in_valid = 1'b1; in_data = {s, 16'(base + k * stepv)};
      do begin @(posedge clk); #0.1; end while (!m_acc);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (mbusy) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int bps[N]  = '{2048, 4096, 6144, 8192, 12288, 16384, 20480, 24576};
    int slps[N] = '{8100, 7400, 6300, 5000, 3300, 1700, 800, 300};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(3);

    cur_req = "R11";
    for (int j = 0; j < N; j++) begin wr(0, j, bps[j]); wr(1, j, slps[j]); end
    wr(2, 0, 32000);

    cur_req = "R10";
    @(negedge clk); start = 1'b1; in_valid = 1'b1; in_data = 17'd500;
    @(negedge clk); start = 1'b0;
    cfg_we = 1'b1; cfg_kind = 2'd0; cfg_idx = 3'd0; cfg_data = 16'd100;
    @(negedge clk); cfg_we = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (mbusy) @(negedge clk);
    idle(5); in_valid = 1'b0; idle(4);
    send(0, 500);
    idle(4);

    cur_req = "R2";
    for (int j = 0; j < N; j++) send(0, bps[j] - 1);
    idle(4);
    cur_req = "R4";
    send(0, 0);
    for (int j = 0; j < N-1; j++) send(0, bps[j]);
    idle(4);
    cur_req = "R3";
    stream(0, 333, 977, 24);
    idle(4);
    cur_req = "R5";
    send(0, bps[N-1]); send(0, 65535); send(0, 40000);
    idle(4);
    cur_req = "R7";
    send(1, 0); send(1, 3000); send(1, 10000); send(1, 65535);
    idle(4);
    cur_req = "R8";
    stream(0, 100, 1500, 17);
    idle(4);
    cur_req = "R9";
    bp_mode = 1'b1;
    stream(1, 50, 811, 40);
    stream(0, 7, 1999, 13);
    idle(30);
    bp_mode = 1'b0;
    idle(6);

    cur_req = "R6";
    for (int j = 0; j < N; j++) wr(1, j, 65535);
    wr(2, 0, 60000);
    kick();
    idle(2);
    send(0, 3000); send(0, 5000); send(0, 30000); send(1, 9000);
    stream(0, 1000, 3000, 8);
    idle(8);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule